// File: doc/BRIEF.md
# Stereo Sample Error Concealment

This block sits after an error-correction decoder in a digital audio path. It takes stereo samples one at a time. Each sample carries a channel tag and a flag that is set when the decoder could not repair that sample. A flagged sample is never passed on as it is. When both neighbours of a flagged sample on the same channel are clean, the flagged sample is rebuilt as their average. When a channel has two or more flagged samples in a row, the block repeats the last clean value and pulls a shared output gain down one step per sample. This fades the output to silence instead of cutting it off.

The block has to see the sample that follows a flagged one, so it holds back one sample per channel. A sample comes out when the next sample on the same channel is accepted. Both channels keep their own neighbour history. They share one gain, so the two sides fade and recover together. After a run of clean samples the fade is released and the gain climbs back to full scale one step per sample.

Top module: `cc_conceal`

## Requirements
- R1: While `rst_n` is low, `in_ready`, `out_valid` and `mute_active` are low. `in_ready` is high from the second rising clock edge after `rst_n` goes high.
- R2: When a sample is accepted on channel c (`in_valid` and `in_ready` both high), the sample held for c is emitted. `out_valid` is high for exactly the following cycle, and `out_chan` equals c. The first sample on each channel after reset emits nothing. No output appears on cycles with nothing accepted.
- R3: An unflagged held sample is emitted unchanged while the gain is at full scale (32).
- R4: A flagged held sample is rebuilt when both of its neighbours on the same channel are unflagged: the sample just before it and the incoming one. The result is floor((before + after) / 2), computed in two's complement.
- R5: Any other flagged held sample is emitted as the channel's most recent unflagged value, or 0 if there has been none since reset. This starts the mute, and `mute_active` is high in the same cycle as that output.
- R6: Every emitted value is floor(base × g / 32). The gain g is 32 after reset. After each emitted sample, g falls by one while the mute is on (it stops at 0) and rises by one while the mute is off (it stops at 32). Each sample uses g as it stood before that sample's own update.
- R7: The mute is released by the fourth consecutive unflagged sample emitted, counting either channel. `mute_active` is low in the same cycle as that fourth output.
- R8: A rebuilt sample resets the recovery count in R7 to zero and does not start the mute.
- R9: Neighbour history is kept separately for each channel. A flag on one channel never changes how the other channel's samples are rebuilt, but both channels are scaled by the one shared gain.
- R10: `in_chan`, `in_bad` and `in_data` have no effect while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can accept a sample |
| in_chan | input | 1 | Channel of input sample (0 left, 1 right) |
| in_bad | input | 1 | Sample flagged as unrepairable |
| in_data | input | 16 | Two's complement input sample |
| out_valid | output | 1 | Output sample present for this cycle |
| out_chan | output | 1 | Channel of output sample |
| out_data | output | 16 | Concealed and scaled output sample |
| mute_active | output | 1 | Soft mute currently engaged |

## Verification
Every result is due one cycle after the acceptance that caused it. This covers the emitted sample, its channel and the gain that scaled it. `mute_active` changes in that same cycle. `in_ready` is due two edges after reset is released. The bench changes its inputs at the falling edge. It updates its behavioural model for the transfer that the next rising edge takes, and compares all outputs at the falling edge after that, one clock later. Idle cycles are compared the same way, so any output that appears without an acceptance is caught.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    K_PASS   = 2'd0,
    K_INTERP = 2'd1,
    K_HOLD   = 2'd2
  } conceal_kind_e;
endpackage

// File: rtl/cc_chan_hist.sv
module cc_chan_hist #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bad,
  output logic              pend_vld,
  output logic [DATA_W-1:0] pend_data,
  output logic              pend_bad,
  output logic              prev_ok,
  output logic [DATA_W-1:0] hold_data
);
  logic              pend_vld_q, pend_vld_d;
  logic [DATA_W-1:0] pend_data_q, pend_data_d;
  logic              pend_bad_q, pend_bad_d;
  logic              prev_ok_q, prev_ok_d;
  logic [DATA_W-1:0] hold_q, hold_d;

  always_comb begin
    pend_vld_d  = pend_vld_q;
    pend_data_d = pend_data_q;
    pend_bad_d  = pend_bad_q;
    prev_ok_d   = prev_ok_q;
    hold_d      = hold_q;
    if (wr_en) begin
      if (pend_vld_q) begin
        prev_ok_d = ~pend_bad_q;
        if (!pend_bad_q) hold_d = pend_data_q;
      end
      pend_vld_d  = 1'b1;
      pend_data_d = wr_data;
      pend_bad_d  = wr_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld_q  <= 1'b0;
      pend_data_q <= '0;
      pend_bad_q  <= 1'b0;
      prev_ok_q   <= 1'b0;
      hold_q      <= '0;
    end else if (wr_en) begin
      pend_vld_q  <= pend_vld_d;
      pend_data_q <= pend_data_d;
      pend_bad_q  <= pend_bad_d;
      prev_ok_q   <= prev_ok_d;
      hold_q      <= hold_d;
    end
  end

  assign pend_vld  = pend_vld_q;
  assign pend_data = pend_data_q;
  assign pend_bad  = pend_bad_q;
  assign prev_ok   = prev_ok_q;
  assign hold_data = hold_q;

  // R2: once a channel holds a sample it always holds one
  a_r2_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vld_q |=> pend_vld_q);
  // R9: history of this channel only moves on its own writes
  a_r9_hist_private: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(hold_q) && $stable(prev_ok_q) && $stable(pend_data_q));
endmodule

// File: rtl/cc_gain.sv
module cc_gain
  import cc_pkg::*;
#(
  parameter int GAIN_LOG    = 5,
  parameter int RECOVER_CNT = 4,
  localparam int GW         = GAIN_LOG + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  input  conceal_kind_e ev_kind,
  output logic [GW-1:0] gain,
  output logic          muting
);
  localparam int CNT_W = $clog2(RECOVER_CNT + 1);
  localparam logic [GW-1:0]    GAIN_FULL = GW'(1) << GAIN_LOG;
  localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(RECOVER_CNT);

  logic [GW-1:0]    gain_q, gain_d;
  logic             mute_q, mute_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    mute_d = mute_q;
    cnt_d  = cnt_q;
    gain_d = gain_q;
    if (ev_valid) begin
      unique case (ev_kind)
        K_HOLD: begin
          mute_d = 1'b1;
          cnt_d  = '0;
        end
        K_INTERP: cnt_d = '0;
        default: begin
          if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
          if (cnt_q >= CNT_MAX - 1'b1) mute_d = 1'b0;
        end
      endcase
      if (mute_d) begin
        if (gain_q != '0) gain_d = gain_q - 1'b1;
      end else begin
        if (gain_q != GAIN_FULL) gain_d = gain_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= GAIN_FULL;
      mute_q <= 1'b0;
      cnt_q  <= '0;
    end else if (ev_valid) begin
      gain_q <= gain_d;
      mute_q <= mute_d;
      cnt_q  <= cnt_d;
    end
  end

  assign gain   = gain_q;
  assign muting = mute_q;

  a_r6_gain_bound: assert property (@(posedge clk) disable iff (!rst_n)
    gain_q <= GAIN_FULL);
  a_r6_gain_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> $stable(gain_q) && $stable(mute_q));
  a_r5_hold_mutes: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == K_HOLD) |=> mute_q);
  a_r8_interp_keeps_mute: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == K_INTERP) |=> mute_q == $past(mute_q));
  a_r6_ramp_down: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == K_HOLD && gain_q != '0) |=> gain_q == $past(gain_q) - 1'b1);
endmodule

// File: rtl/cc_scale.sv
module cc_scale #(
  parameter int DATA_W   = 16,
  parameter int GAIN_LOG = 5,
  localparam int GW      = GAIN_LOG + 1
) (
  input  logic [DATA_W-1:0] base,
  input  logic [GW-1:0]     gain,
  output logic [DATA_W-1:0] scaled
);
  localparam int PW = DATA_W + GAIN_LOG + 2;

  logic signed [PW-1:0] base_x, gain_x, prod, shifted;

  always_comb begin
    base_x  = $signed({{(GAIN_LOG + 2){base[DATA_W-1]}}, base});
    gain_x  = $signed({{(DATA_W + 1){1'b0}}, gain});
    prod    = base_x * gain_x;
    shifted = prod >>> GAIN_LOG;
    scaled  = shifted[DATA_W-1:0];
  end
endmodule

// File: rtl/cc_conceal.sv
module cc_conceal
  import cc_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int NUM_CH      = 2,
  parameter int GAIN_LOG    = 5,
  parameter int RECOVER_CNT = 4,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CH_W-1:0]   in_chan,
  input  logic              in_bad,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_chan,
  output logic [DATA_W-1:0] out_data,
  output logic              mute_active
);
  localparam int GW = GAIN_LOG + 1;
  localparam logic [GW-1:0] GAIN_FULL = GW'(1) << GAIN_LOG;

  // reset: asserted at once, released on the second edge
  logic [1:0] rst_s_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_s_q <= '0;
    else        rst_s_q <= {rst_s_q[0], 1'b1};
  end
  assign rst_i_n  = rst_s_q[1];
  assign in_ready = rst_i_n;

  logic accept;
  assign accept = in_valid & rst_i_n;

  // per-channel neighbour history
  logic [NUM_CH-1:0] wr_en_a, pend_vld_a, pend_bad_a, prev_ok_a;
  logic [DATA_W-1:0] pend_data_a [NUM_CH];
  logic [DATA_W-1:0] hold_a      [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign wr_en_a[ch] = accept && (in_chan == CH_W'(ch));
    cc_chan_hist #(.DATA_W(DATA_W)) i_hist (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .wr_en    (wr_en_a[ch]),
      .wr_data  (in_data),
      .wr_bad   (in_bad),
      .pend_vld (pend_vld_a[ch]),
      .pend_data(pend_data_a[ch]),
      .pend_bad (pend_bad_a[ch]),
      .prev_ok  (prev_ok_a[ch]),
      .hold_data(hold_a[ch])
    );
  end

  // selection and classification
  logic              pend_vld_s, pend_bad_s, prev_ok_s, emit;
  logic [DATA_W-1:0] pend_data_s, hold_s, base;
  logic [DATA_W:0]   pair_sum;
  conceal_kind_e     kind;

  always_comb begin
    pend_vld_s  = pend_vld_a[in_chan];
    pend_bad_s  = pend_bad_a[in_chan];
    prev_ok_s   = prev_ok_a[in_chan];
    pend_data_s = pend_data_a[in_chan];
    hold_s      = hold_a[in_chan];
    emit        = accept & pend_vld_s;
    pair_sum    = {hold_s[DATA_W-1], hold_s} + {in_data[DATA_W-1], in_data};
    if (!pend_bad_s) begin
      kind = K_PASS;
      base = pend_data_s;
    end else if (prev_ok_s && !in_bad) begin
      kind = K_INTERP;
      base = pair_sum[DATA_W:1];
    end else begin
      kind = K_HOLD;
      base = hold_s;
    end
  end

  logic [GW-1:0]     gain;
  logic              muting;
  logic [DATA_W-1:0] scaled;

  cc_gain #(.GAIN_LOG(GAIN_LOG), .RECOVER_CNT(RECOVER_CNT)) i_gain (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .ev_valid(emit),
    .ev_kind (kind),
    .gain    (gain),
    .muting  (muting)
  );

  cc_scale #(.DATA_W(DATA_W), .GAIN_LOG(GAIN_LOG)) i_scale (
    .base  (base),
    .gain  (gain),
    .scaled(scaled)
  );

  // output register
  logic              out_valid_q, out_valid_d;
  logic [CH_W-1:0]   out_chan_q, out_chan_d;
  logic [DATA_W-1:0] out_data_q, out_data_d;

  always_comb begin
    out_valid_d = emit;
    out_chan_d  = out_chan_q;
    out_data_d  = out_data_q;
    if (emit) begin
      out_chan_d = in_chan;
      out_data_d = scaled;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      out_valid_q <= 1'b0;
      out_chan_q  <= '0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= out_valid_d;
      out_chan_q  <= out_chan_d;
      out_data_q  <= out_data_d;
    end
  end

  assign out_valid   = out_valid_q;
  assign out_chan    = out_chan_q;
  assign out_data    = out_data_q;
  assign mute_active = muting;

  a_r2_emit_next: assert property (@(posedge clk) disable iff (!rst_i_n)
    (accept && pend_vld_s) |=> out_valid && out_chan == $past(in_chan));
  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(accept && pend_vld_s) |=> !out_valid);
  a_r3_pass_full: assert property (@(posedge clk) disable iff (!rst_i_n)
    (accept && pend_vld_s && !pend_bad_s && gain == GAIN_FULL) |=> out_data == $past(pend_data_s));
  a_r1_ready_reset: assert property (@(posedge clk)
    !rst_n |-> !in_ready && !mute_active);
endmodule

// File: tb/test_cc_conceal.sv
module test_cc_conceal;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_chan, in_bad;
  logic [15:0] in_data;
  logic        in_ready, out_valid, out_chan, mute_active;
  logic [15:0] out_data;

  int total = 0;
  int bad   = 0;

  // reference model state
  int pv[2], pd[2], pb[2], pok[2], hold[2];
  int gain, muting, cnt;
  int exp_v, exp_c, exp_d;

  always #10 clk = ~clk;

  cc_conceal i_cc_conceal (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_chan(in_chan), .in_bad(in_bad), .in_data(in_data),
    .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data),
    .mute_active(mute_active)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  // one clock: drive at falling edge, compare at the next falling edge
  task automatic step(input bit v, input bit ch, input bit bd, input int d, input string tag);
    int c, k, base;
    in_valid = v;
    in_chan  = ch;
    in_bad   = bd;
    in_data  = d[15:0];
    exp_v = 0;
    if (v) begin
      c = ch;
      if (pv[c] != 0) begin
        if (pb[c] == 0) begin k = 0; base = pd[c]; end
        else if (pok[c] != 0 && !bd) begin k = 1; base = (hold[c] + d) >>> 1; end
        else begin k = 2; base = hold[c]; end
        exp_v = 1;
        exp_c = c;
        exp_d = (base * gain) >>> 5;
        if (k == 2) begin muting = 1; cnt = 0; end
        else if (k == 1) cnt = 0;
        else begin
          if (cnt < 4) cnt++;
          if (cnt >= 4) muting = 0;
        end
        if (muting != 0) begin if (gain > 0) gain--; end
        else if (gain < 32) gain++;
        pok[c] = (pb[c] == 0);
        if (pb[c] == 0) hold[c] = pd[c];
      end
      pv[c] = 1; pd[c] = d; pb[c] = bd;
    end
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == exp_v[0], {tag, " out_valid"}, out_valid, exp_v);
    if (exp_v != 0) begin
      chk(out_chan == exp_c[0], {tag, " out_chan"}, out_chan, exp_c);
      chk($signed(out_data) == exp_d, {tag, " out_data"}, $signed(out_data), exp_d);
    end
    chk(mute_active == muting[0], {tag, " mute_active"}, mute_active, muting);
  endtask

  initial begin
    #(20ns * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lfsr;
    for (int i = 0; i < 2; i++) begin pv[i] = 0; pd[i] = 0; pb[i] = 0; pok[i] = 0; hold[i] = 0; end
    gain = 32; muting = 0; cnt = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_chan = 1'b0; in_bad = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0, "R1 ready in reset", in_ready, 0);
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    chk(mute_active == 1'b0, "R1 mute in reset", mute_active, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready after release", in_ready, 1);

    // R2: first sample per channel gives nothing, then one-sample delay
    step(1, 0, 0, 100, "R2 first L");
    step(1, 1, 0, -200, "R2 first R");
    step(0, 0, 0, 0, "R2 idle");
    step(1, 0, 0, 300, "R3 pass L");
    step(1, 1, 0, -400, "R3 pass R");
    // R4: interpolation, positive and negative floor
    step(1, 0, 1, 7777, "R4 flagged L");
    step(1, 1, 0, -3, "R9 R clean during L flag");
    step(1, 0, 0, 1001, "R4 interp L");
    step(1, 1, 1, 5555, "R4 flagged R");
    step(1, 0, 0, 50, "R9 L clean during R flag");
    step(1, 1, 0, 0, "R4 interp R neg floor");
    // R10: junk while not valid
    step(0, 1, 1, 12345, "R10 ignored");
    step(0, 0, 1, -9999, "R10 ignored");
    step(1, 1, 0, 32767, "R10 after junk");
    step(1, 1, 0, -32768, "R3 extremes");
    // R5/R6: burst on L starts the fade
    step(1, 0, 1, 1, "R5 burst a");
    step(1, 0, 1, 2, "R5 burst b");
    step(1, 0, 1, 3, "R5 burst c");
    for (int i = 0; i < 40; i++) begin
      step(1, i[0], (i % 7) == 3, 1000 + 37 * i, "R6 fade");
    end
    // R7/R8: clean run releases mute, interp resets count
    step(1, 0, 1, 20, "R5 retrigger");
    step(1, 0, 1, 21, "R5 retrigger");
    step(1, 0, 0, 22, "R7 clean");
    step(1, 1, 0, 23, "R7 clean");
    step(1, 0, 1, 24, "R8 flag");
    step(1, 0, 0, 25, "R8 interp resets");
    for (int i = 0; i < 44; i++) begin
      step(1, i[0], 1'b0, -2000 + 91 * i, "R7 recover");
    end
    // mixed pattern, both channels
    lfsr = 32'h1ace;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[7:5] != 3'd0, lfsr[8], lfsr[11:9] == 3'd0 || lfsr[13:12] == 2'd0 && i > 300,
           $signed(lfsr[31:16]), "R9 mixed");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule